// File: doc/BRIEF.md
# Configurable GPIO Port Pin Controller

This block holds the output latch and the per-pin mode settings for an 8-bit microcontroller I/O port. It turns them into driver enables for each pad and conditions the pad input on its way back. Two configuration registers are written through a small write-only register port. Each pin takes its mode from its own bit in each of the two registers, so pins are configured independently.

Each pin gets four registered driver enables: a strong pull-down, a strong pull-up, a weak pull-up and a very weak pull-up. The pad itself sits outside this block. In quasi-bidirectional mode, a latched one holds the pin high only weakly, so another device can pull it low. A 0-to-1 latch change adds a short strong pull-up pulse that speeds the rising edge. Some pins are restricted to certain modes, and these limits are fixed at elaboration. Every pad input passes through a two-flop synchronizer and a glitch filter before it reaches `in_filt`.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every pin is input-only, the output latch holds all ones, every driver enable is 0 and `in_filt` is 0.
- R2: A write with `wr_addr` 0 loads the output latch, address 1 loads the first configuration register (cfg1) and address 2 loads the second (cfg2). Address 3 is ignored. A pin's mode is {cfg1 bit, cfg2 bit}: 00 quasi-bidirectional, 01 push-pull, 10 input-only, 11 open-drain. Driver enables reflect a write one clock after the write edge.
- R3: In quasi-bidirectional mode, a latch value of 0 enables only the pull-down. A latch value of 1 keeps the very weak pull-up on and the pull-down off. The pull-down and a pull-up are never on together.
- R4: In quasi-bidirectional mode, a 0-to-1 latch change turns on the strong pull-up for exactly two clock cycles. No pulse occurs without such a change.
- R5: In quasi-bidirectional mode, the weak pull-up is on while the latch is 1 and the synchronized pad input reads 1.
- R6: In push-pull mode, the strong pull-up equals the latch value and the pull-down equals its inverse. The weak pull-ups stay off.
- R7: In open-drain mode, all pull-ups are off and the pull-down is on only while the latch holds 0.
- R8: In input-only mode, every driver enable is off.
- R9: Pin 5 is always input-only: its enables stay 0 whatever is written.
- R10: Pins 2 and 3 have their cfg1 bit forced to 1, so a written 00 gives input-only and 01 gives open-drain. They never enable a pull-up.
- R11: `in_filt` takes a new pad value only after the synchronized value has differed from it on 3 consecutive clock edges. A change held at the pad appears at the fifth rising edge after it. A pulse of 2 clocks is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 latch, 1 cfg1, 2 cfg2 |
| wr_data | input | 8 | Write data, one bit per pin |
| pad_in | input | 8 | Raw pad input levels |
| en_pd | output | 8 | Strong pull-down enable per pin |
| en_pu_strong | output | 8 | Strong pull-up enable per pin |
| en_pu_weak | output | 8 | Weak pull-up enable per pin |
| en_pu_vweak | output | 8 | Very weak pull-up enable per pin |
| in_filt | output | 8 | Synchronized, glitch-filtered input |

## Verification
The bench counts the strong pull-up pulse cycle by cycle after a 0-to-1 latch write. A design with an off-by-one counter would show a pulse of one or three cycles, and one that pulses on any latch write would pull up strongly with no edge. It writes illegal codes to the restricted pins and checks their enables. A missing legalization would show pull-ups on pins 2 and 3 or any drive on pin 5. It sends 2-cycle glitches of both polarities and a 3-cycle pulse to the filter. A filter with the wrong threshold would pass the glitch or drop the held pulse, and a wrong latency would move the edge away from the fifth clock. It also writes the unused address and checks that an incomplete decode leaves the enables unchanged.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    MODE_QUASI     = 2'b00,
    MODE_PUSHPULL  = 2'b01,
    MODE_INPUT     = 2'b10,
    MODE_OPENDRAIN = 2'b11
  } pin_mode_e;

  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] REG_LATCH = 2'd0;
  localparam logic [ADDR_W-1:0] REG_CFG1  = 2'd1;
  localparam logic [ADDR_W-1:0] REG_CFG2  = 2'd2;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS         = 8,
  parameter int unsigned STRONG_CYCLES = 2,
  parameter int unsigned FIXED_IN_PIN  = 5,
  parameter int unsigned OD_PIN_A      = 2,
  parameter int unsigned OD_PIN_B      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NPINS-1:0]  wr_data,
  output logic [NPINS-1:0]  cfg1_q,
  output logic [NPINS-1:0]  cfg2_q,
  output logic [NPINS-1:0]  latch_q,
  output logic [NPINS-1:0]  pulse_on
);
  localparam int unsigned CNT_W = $clog2(STRONG_CYCLES + 1);
  localparam logic [NPINS-1:0] ONE        = {{(NPINS-1){1'b0}}, 1'b1};
  localparam logic [NPINS-1:0] FIXED_MASK = ONE << FIXED_IN_PIN;
  localparam logic [NPINS-1:0] LIMIT_MASK = FIXED_MASK | (ONE << OD_PIN_A) | (ONE << OD_PIN_B);

  logic latch_wr;
  assign latch_wr = wr_en && (wr_addr == REG_LATCH);

  // Mode legalization happens at the write port so stored state is always legal
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg1_q  <= '1;
      cfg2_q  <= '0;
      latch_q <= '1;
    end else if (wr_en) begin
      case (wr_addr)
        REG_LATCH: latch_q <= wr_data;
        REG_CFG1:  cfg1_q  <= wr_data | LIMIT_MASK;
        REG_CFG2:  cfg2_q  <= wr_data & ~FIXED_MASK;
        default:   ;
      endcase
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pulse
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt <= '0;
      end else if (latch_wr && wr_data[i] && !latch_q[i]) begin
        cnt <= CNT_W'(STRONG_CYCLES);
      end else if (latch_wr && !wr_data[i]) begin
        cnt <= '0;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
    assign pulse_on[i] = (cnt != '0);

    // R4
    pulse_needs_high_chk: assert property (@(posedge clk) disable iff (rst)
      pulse_on[i] |-> latch_q[i]);
  end
endmodule

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
  parameter int unsigned NPINS    = 8,
  parameter int unsigned FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pad_i,
  output logic [NPINS-1:0] sync_o,
  output logic [NPINS-1:0] filt_o
);
  localparam int unsigned RC_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic [NPINS-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_o <= '0;
    end else begin
      meta_q <= pad_i;
      sync_o <= meta_q;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_filt
    logic [RC_W-1:0] run_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        run_q     <= '0;
        filt_o[i] <= 1'b0;
      end else if (sync_o[i] == filt_o[i]) begin
        run_q <= '0;
      end else if (run_q == RC_W'(FILT_LEN - 1)) begin
        run_q     <= '0;
        filt_o[i] <= sync_o[i];
      end else begin
        run_q <= run_q + 1'b1;
      end
    end

    // R11
    filt_steady_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(filt_o[i]) |-> (filt_o[i] == $past(sync_o[i])) && ($past(sync_o[i]) == $past(sync_o[i], 2)));
  end
endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv
  import gpio_port_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pin_mode_e mode,
  input  logic      lat,
  input  logic      pulse,
  input  logic      sync_in,
  output logic      pd_o,
  output logic      pus_o,
  output logic      puw_o,
  output logic      puv_o
);
  logic pd_d, pus_d, puw_d, puv_d;

  always_comb begin
    pd_d  = 1'b0;
    pus_d = 1'b0;
    puw_d = 1'b0;
    puv_d = 1'b0;
    case (mode)
      MODE_QUASI: begin
        pd_d  = !lat;
        pus_d = pulse;
        puw_d = lat && sync_in;
        puv_d = lat;
      end
      MODE_PUSHPULL: begin
        pd_d  = !lat;
        pus_d = lat;
      end
      MODE_OPENDRAIN: pd_d = !lat;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_o  <= 1'b0;
      pus_o <= 1'b0;
      puw_o <= 1'b0;
      puv_o <= 1'b0;
    end else begin
      pd_o  <= pd_d;
      pus_o <= pus_d;
      puw_o <= puw_d;
      puv_o <= puv_d;
    end
  end

  // R3
  no_fight_chk: assert property (@(posedge clk) disable iff (rst)
    !(pd_o && (pus_o || puw_o || puv_o)));
  // R8
  inonly_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_INPUT) |=> !(pd_o || pus_o || puw_o || puv_o));
  // R7
  od_no_pullup_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OPENDRAIN) |=> !(pus_o || puw_o || puv_o));
  // R6
  pushpull_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_PUSHPULL) |=> (pus_o == $past(lat)) && (pd_o == !$past(lat)) && !puw_o && !puv_o);
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS         = 8,
  parameter int unsigned STRONG_CYCLES = 2,
  parameter int unsigned FILT_LEN      = 3,
  parameter int unsigned FIXED_IN_PIN  = 5,
  parameter int unsigned OD_PIN_A      = 2,
  parameter int unsigned OD_PIN_B      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NPINS-1:0]  wr_data,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  en_pd,
  output logic [NPINS-1:0]  en_pu_strong,
  output logic [NPINS-1:0]  en_pu_weak,
  output logic [NPINS-1:0]  en_pu_vweak,
  output logic [NPINS-1:0]  in_filt
);
  logic [NPINS-1:0] cfg1_q, cfg2_q, latch_q, pulse_on, sync_q;

  gpio_cfg_regs #(
    .NPINS(NPINS), .STRONG_CYCLES(STRONG_CYCLES), .FIXED_IN_PIN(FIXED_IN_PIN),
    .OD_PIN_A(OD_PIN_A), .OD_PIN_B(OD_PIN_B)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg1_q(cfg1_q), .cfg2_q(cfg2_q), .latch_q(latch_q), .pulse_on(pulse_on)
  );

  gpio_in_filter #(.NPINS(NPINS), .FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .pad_i(pad_in), .sync_o(sync_q), .filt_o(in_filt)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pin_mode_e mode;
    assign mode = pin_mode_e'({cfg1_q[i], cfg2_q[i]});
    gpio_pin_drv u_drv (
      .clk(clk), .rst(rst), .mode(mode), .lat(latch_q[i]), .pulse(pulse_on[i]),
      .sync_in(sync_q[i]), .pd_o(en_pd[i]), .pus_o(en_pu_strong[i]),
      .puw_o(en_pu_weak[i]), .puv_o(en_pu_vweak[i])
    );
  end

  // R9
  fixed_pin_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(en_pd[FIXED_IN_PIN] || en_pu_strong[FIXED_IN_PIN] || en_pu_weak[FIXED_IN_PIN] || en_pu_vweak[FIXED_IN_PIN]));
  // R10
  od_pins_no_pullup_chk: assert property (@(posedge clk) disable iff (rst)
    !(en_pu_strong[OD_PIN_A] || en_pu_weak[OD_PIN_A] || en_pu_vweak[OD_PIN_A] ||
      en_pu_strong[OD_PIN_B] || en_pu_weak[OD_PIN_B] || en_pu_vweak[OD_PIN_B]));
endmodule

// File: tb/gpio_port_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] pad_in = '0;
  logic [7:0] en_pd, en_pu_strong, en_pu_weak, en_pu_vweak, in_filt;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  gpio_port_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pad_in(pad_in), .en_pd(en_pd), .en_pu_strong(en_pu_strong),
    .en_pu_weak(en_pu_weak), .en_pu_vweak(en_pu_vweak), .in_filt(in_filt)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pd", en_pd, 8'h00);
    chk("R1 pu", en_pu_strong | en_pu_weak | en_pu_vweak, 8'h00);
    chk("R1 filt", in_filt, 8'h00);
  endtask

  task automatic t_quasi();
    wr(2'd1, 8'h00);
    cyc(1);
    chk("R3 vweak latch1", en_pu_vweak, 8'hD3);
    chk("R4 no pulse without edge", en_pu_strong, 8'h00);
    chk("R3 pd off latch1", en_pd, 8'h00);
    wr(2'd0, 8'h00);
    cyc(1);
    chk("R3 pd latch0", en_pd, 8'hD3);
    chk("R10 pins2,3 input-only from 00", en_pd & 8'h0C, 8'h00);
    chk("R3 vweak off latch0", en_pu_vweak, 8'h00);
    wr(2'd0, 8'hFF);
    cyc(1);
    chk("R4 pulse cycle1", en_pu_strong, 8'hD3);
    cyc(1);
    chk("R4 pulse cycle2", en_pu_strong, 8'hD3);
    cyc(1);
    chk("R4 pulse ended", en_pu_strong, 8'h00);
  endtask

  task automatic t_weak();
    pad_in = 8'hFF;
    cyc(4);
    chk("R5 weak on", en_pu_weak, 8'hD3);
    pad_in = 8'h0F;
    cyc(4);
    chk("R5 weak follows input", en_pu_weak, 8'h03);
    pad_in = 8'h00;
    cyc(8);
    chk("R5 weak off", en_pu_weak, 8'h00);
    wr(2'd3, 8'h00);
    cyc(1);
    chk("R2 unused addr ignored", en_pu_vweak, 8'hD3);
  endtask

  task automatic t_pushpull();
    wr(2'd2, 8'hFF);
    cyc(1);
    chk("R6 pp high", en_pu_strong, 8'hD3);
    chk("R6 pp no weak", en_pu_vweak | en_pu_weak, 8'h00);
    wr(2'd0, 8'h00);
    cyc(1);
    chk("R6 pp low pd", en_pd, 8'hDF);
    chk("R6 pp low no pu", en_pu_strong, 8'h00);
    chk("R9 pin5 idle", (en_pd | en_pu_strong | en_pu_weak | en_pu_vweak) & 8'h20, 8'h00);
  endtask

  task automatic t_opendrain();
    wr(2'd1, 8'hFF);
    cyc(1);
    chk("R7 od pd latch0", en_pd, 8'hDF);
    wr(2'd0, 8'hAA);
    cyc(1);
    chk("R7 od pd pattern", en_pd, 8'h55);
    cyc(1);
    chk("R7 od no pullup", en_pu_strong | en_pu_weak | en_pu_vweak, 8'h00);
  endtask

  task automatic t_input();
    wr(2'd2, 8'h00);
    cyc(1);
    chk("R8 input quiet", en_pd | en_pu_strong | en_pu_weak | en_pu_vweak, 8'h00);
    wr(2'd0, 8'h00);
    cyc(1);
    chk("R8 input quiet latch0", en_pd, 8'h00);
  endtask

  task automatic t_filter();
    pad_in = 8'h01;
    cyc(4);
    chk("R11 not yet", in_filt, 8'h00);
    cyc(1);
    chk("R11 fifth edge", in_filt, 8'h01);
    pad_in = 8'h03;
    cyc(2);
    pad_in = 8'h01;
    cyc(6);
    chk("R11 high glitch dropped", in_filt, 8'h01);
    pad_in = 8'h00;
    cyc(2);
    pad_in = 8'h01;
    cyc(6);
    chk("R11 low glitch dropped", in_filt, 8'h01);
    pad_in = 8'h03;
    cyc(3);
    pad_in = 8'h01;
    cyc(2);
    chk("R11 3-cycle pulse passes", in_filt, 8'h03);
    cyc(6);
    chk("R11 returns", in_filt, 8'h01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_quasi();
    t_weak();
    t_pushpull();
    t_opendrain();
    t_input();
    t_filter();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule